// File: doc/BRIEF.md
# Shift-then-Signed-Saturate Execution Unit

This unit carries out one processor operation: it shifts a 32-bit source operand and clamps the result to a signed range whose width is chosen at run time. A shift-kind bit picks a logical left shift or an arithmetic right shift, and a 5-bit amount field gives the distance. The shifted word is then read as a signed integer. It is clamped to N bits, where N is the 5-bit width field plus one. The clamped N-bit value is sign-extended back to a full word.

The shift and clamp path is purely combinational, so the result and the per-operation saturation indication follow the inputs in the same cycle. A sticky saturation flag is the only state in the unit. The flag is set when a strobed operation clamps its value. It is cleared only by reset or by an explicit synchronous clear. The surrounding pipeline supplies operands, applies the result, and drives the strobe only when the operation actually executes. The carry flag plays no part in the unit.

Top module: `sat_shift_unit`

## Requirements
- R1: The clamp width is N = width field + 1 (1 to 32 bits). A value above 2^(N-1)-1 becomes 2^(N-1)-1, and a value below -2^(N-1) becomes -2^(N-1).
- R2: Shift-kind bit 0 selects a logical left shift. Shift-kind bit 1 selects an arithmetic right shift by the decoded amount.
- R3: For a left shift, the amount field is the distance (0 to 31, where 0 means no shift). Bits moved above bit 31 are discarded before the word is read as signed.
- R4: For a right shift, amount field 0 means a shift of 32, which yields 32 copies of the source sign bit. Fields 1 to 31 shift by that value.
- R5: The shift is applied first. The clamp then acts on the shifted value, not on the raw source.
- R6: Every result bit above bit N-1 equals bit N-1, so the output is the sign extension of the N-bit clamped value.
- R7: The saturation output is 1 exactly when clamping changed the shifted value. When the strobe is high and the saturation output is 1, the sticky flag is 1 from the next clock edge.
- R8: The sticky flag keeps its value on any edge where no clear is requested and no strobed operation saturates, including operations that saturate while the strobe is low.
- R9: A synchronous clear drives the sticky flag to 0 on the next edge. If a strobed saturating operation arrives in the same cycle, the flag is set instead.
- R10: An active-low synchronous reset drives the sticky flag to 0.
- R11: With N = 32 the clamp never triggers. The result equals the shifted operand and the saturation output stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Operation strobe; the sticky flag may be updated only while this is high |
| clr_i | input | 1 | Synchronous clear of the sticky flag |
| src_i | input | 32 | Source operand |
| shift_asr_i | input | 1 | 0 = logical left shift, 1 = arithmetic right shift |
| shamt_i | input | 5 | Shift amount field (0 means 32 for right shifts) |
| satw_i | input | 5 | Saturation width field, N-1 |
| result_o | output | 32 | Sign-extended saturated result |
| sat_o | output | 1 | Clamping changed the value in this operation |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
The result and the saturation output have no register in their path. The bench therefore drives operands just after a falling edge and compares them one nanosecond later, within the same cycle. The sticky flag changes on the first rising edge after the strobe, clear or reset. Its checks sample one nanosecond after that edge, well before the next falling edge, when inputs move again. The full sweep of operand patterns, shift kinds, amounts and widths keeps the strobe low, and the flag is observed afterwards to confirm that those operations left it unchanged.

// File: rtl/sat_shift_pkg.sv
// Package: shared encodings for the shift-then-saturate unit.
// Assumes: the shift-kind input is a single bit, 0 = left, 1 = right.
package sat_shift_pkg;
    typedef enum logic {
        SHK_LEFT  = 1'b0,
        SHK_RIGHT = 1'b1
    } shift_kind_e;
endpackage

// File: rtl/sat_shift_shifter.sv
// Module: barrel shifter stage.
// Does: logical left shift, or arithmetic right shift in which amount 0 means DATA_W.
// Assumes: DATA_W is a power of two and AMT_W = log2(DATA_W).
module sat_shift_shifter
    import sat_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic              kind_i,
    input  logic [AMT_W-1:0]  amt_i,
    output logic [DATA_W-1:0] shifted_o
);
    localparam int EXT_W = 2 * DATA_W;

    shift_kind_e             kind;
    logic [AMT_W:0]          right_amt;
    logic [EXT_W-1:0]        left_wide;
    logic signed [EXT_W-1:0] src_sext;
    logic signed [EXT_W-1:0] right_wide;

    // Purpose: form both shifts at double width, then keep the low word of the selected one.
    always_comb begin
        kind       = shift_kind_e'(kind_i);
        right_amt  = (amt_i == '0) ? (AMT_W+1)'(DATA_W) : {1'b0, amt_i};
        left_wide  = {{DATA_W{1'b0}}, src_i} << amt_i;
        src_sext   = {{DATA_W{src_i[DATA_W-1]}}, src_i};
        right_wide = src_sext >>> right_amt;
        shifted_o  = (kind == SHK_RIGHT) ? right_wide[DATA_W-1:0]
                                         : left_wide[DATA_W-1:0];
    end
endmodule

// File: rtl/sat_shift_clamp.sv
// Module: signed clamp to a run-time width.
// Does: clamps a signed word to N = width_i + 1 bits and returns the value sign-extended.
// Assumes: width_i is at most DATA_W-1.
module sat_shift_clamp #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 5
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic [AMT_W-1:0]  width_i,
    output logic [DATA_W-1:0] res_o,
    output logic              sat_o
);
    localparam int CW = DATA_W + 1;

    logic signed [CW-1:0] val_x;
    logic signed [CW-1:0] lim_hi;
    logic signed [CW-1:0] lim_lo;

    // Purpose: derive the bounds one bit wider than the data and compare signed.
    always_comb begin
        val_x  = {val_i[DATA_W-1], val_i};
        lim_hi = (CW'(1) << width_i) - CW'(1);
        lim_lo = -(CW'(1) << width_i);
        if (val_x > lim_hi) begin
            res_o = lim_hi[DATA_W-1:0];
            sat_o = 1'b1;
        end else if (val_x < lim_lo) begin
            res_o = lim_lo[DATA_W-1:0];
            sat_o = 1'b1;
        end else begin
            res_o = val_i;
            sat_o = 1'b0;
        end
    end
endmodule

// File: rtl/sat_shift_flag.sv
// Module: sticky saturation flag.
// Does: sets on a strobed saturation and clears on request; set wins over clear.
// Assumes: synchronous active-low reset.
module sat_shift_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic sat_i,
    input  logic clr_i,
    output logic flag_o
);
    // Purpose: hold the flag, with priority reset, set, clear, hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (valid_i && sat_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sat_shift_unit.sv
// Module: shift-then-signed-saturate execution unit (top).
// Does: shifts the source, clamps it to a signed width chosen at run time, and keeps a sticky flag.
// Assumes: the result is used in the same cycle; only the flag is registered.
module sat_shift_unit #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       valid_i,
    input  logic                       clr_i,
    input  logic [DATA_W-1:0]          src_i,
    input  logic                       shift_asr_i,
    input  logic [$clog2(DATA_W)-1:0]  shamt_i,
    input  logic [$clog2(DATA_W)-1:0]  satw_i,
    output logic [DATA_W-1:0]          result_o,
    output logic                       sat_o,
    output logic                       sticky_o
);
    localparam int AMT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] shifted;

    sat_shift_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .src_i     (src_i),
        .kind_i    (shift_asr_i),
        .amt_i     (shamt_i),
        .shifted_o (shifted)
    );

    sat_shift_clamp #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_clamp (
        .val_i   (shifted),
        .width_i (satw_i),
        .res_o   (result_o),
        .sat_o   (sat_o)
    );

    sat_shift_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .sat_i   (sat_o),
        .clr_i   (clr_i),
        .flag_o  (sticky_o)
    );
endmodule

// File: rtl/sat_shift_unit_chk.sv
// Module: assertion checker bound to sat_shift_unit.
// Does: checks the flag sequencing, the sign extension and the full-width case.
// Assumes: the same DATA_W as the unit it is bound to.
module sat_shift_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      valid_i,
    input logic                      clr_i,
    input logic [$clog2(DATA_W)-1:0] satw_i,
    input logic [DATA_W-1:0]         result_o,
    input logic                      sat_o,
    input logic                      sticky_o
);
    logic signed [DATA_W-1:0] upper_part;

    // Purpose: bits at and above position N-1, moved down to the bottom.
    always_comb upper_part = $signed(result_o) >>> satw_i;

    p_set_on_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && sat_o) |=> sticky_o);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !(valid_i && sat_o)) |=> (sticky_o == $past(sticky_o)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(valid_i && sat_o)) |=> !sticky_o);

    p_sign_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_part == '0) || (upper_part == '1));

    p_full_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (satw_i == '1) |-> !sat_o);
endmodule

bind sat_shift_unit sat_shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .clr_i    (clr_i),
    .satw_i   (satw_i),
    .result_o (result_o),
    .sat_o    (sat_o),
    .sticky_o (sticky_o)
);

// File: tb/sat_shift_unit_test.sv
`timescale 1ns/1ps
module sat_shift_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [31:0] src_i = '0;
    logic        shift_asr_i = 1'b0;
    logic [4:0]  shamt_i = '0;
    logic [4:0]  satw_i = '0;
    logic [31:0] result_o;
    logic        sat_o;
    logic        sticky_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sat_shift_unit uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .clr_i(clr_i),
        .src_i(src_i), .shift_asr_i(shift_asr_i), .shamt_i(shamt_i),
        .satw_i(satw_i), .result_o(result_o), .sat_o(sat_o), .sticky_o(sticky_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (src=%h asr=%0d amt=%0d w=%0d)",
                     req, act, exp, src_i, shift_asr_i, shamt_i, satw_i);
        end
    endtask

    // Arithmetic model: shift as multiply/floor-divide, then clamp to N = w+1 bits.
    task automatic model(input logic [31:0] s, input bit asr, input int amt, input int w,
                         output logic [31:0] r, output bit sat);
        longint sv, p, t, hi, lo, c;
        if (!asr) begin
            t  = (longint'(s) * (longint'(1) << amt)) % (longint'(1) << 32);
            sv = (t >= (longint'(1) << 31)) ? t - (longint'(1) << 32) : t;
        end else begin
            p  = longint'(1) << ((amt == 0) ? 32 : amt);
            t  = (s[31]) ? longint'(s) - (longint'(1) << 32) : longint'(s);
            sv = (t >= 0) ? t / p : -(((-t) + p - 1) / p);
        end
        hi = (longint'(1) << w) - 1;
        lo = -(longint'(1) << w);
        c  = (sv > hi) ? hi : ((sv < lo) ? lo : sv);
        sat = (c != sv);
        r = c[31:0];
    endtask

    task automatic apply(input logic [31:0] s, input bit asr, input int amt, input int w);
        @(negedge clk);
        src_i = s; shift_asr_i = asr; shamt_i = 5'(amt); satw_i = 5'(w);
        #1;
    endtask

    task automatic edge_then_sample;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [12];
        logic [31:0] er;
        bit          es;
        string       tag;
        pats = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                 32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_8000,
                 32'hFFFF_7FFF, 32'h4000_0000, 32'h0000_00FF, 32'hC000_0001};

        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset", {31'b0, sticky_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep with strobe low: datapath checks, flag must stay 0 (R8)
        for (int pi = 0; pi < 12; pi++) begin
            for (int k = 0; k < 2; k++) begin
                for (int a = 0; a < 32; a++) begin
                    for (int w = 0; w < 32; w++) begin
                        apply(pats[pi], bit'(k), a, w);
                        model(pats[pi], bit'(k), a, w, er, es);
                        if (w == 31)            tag = "R11 full width";
                        else if (k == 1 && a == 0) tag = "R4 right by 32";
                        else if (k == 1)        tag = "R2 right shift";
                        else if (a == 0)        tag = "R1 clamp unshifted";
                        else                    tag = "R3 left shift";
                        check(tag, result_o, er);
                        check("R7 sat output", {31'b0, sat_o}, {31'b0, es});
                        check("R6 sign extension", result_o,
                              32'($signed(result_o << (31 - w)) >>> (31 - w)));
                    end
                end
            end
        end
        edge_then_sample;
        check("R8 no strobe no change", {31'b0, sticky_o}, 32'd0);

        // R5: shift precedes clamp (0x40 would saturate at N=4, 0x40>>4 = 4 does not)
        apply(32'h0000_0040, 1'b1, 4, 3);
        check("R5 shift before clamp", result_o, 32'd4);
        check("R5 no saturation", {31'b0, sat_o}, 32'd0);
        // R3: left shift wraps into sign bit: 0x3 << 31 -> 0x80000000, N=8 -> -128
        apply(32'h0000_0003, 1'b0, 31, 7);
        check("R3 discarded high bits", result_o, 32'hFFFF_FF80);
        // R4: right by 32 of negative source
        apply(32'h8000_0001, 1'b1, 0, 31);
        check("R4 all sign bits", result_o, 32'hFFFF_FFFF);
        // R1: one-bit width clamps positive to 0, negative to -1
        apply(32'h0000_0005, 1'b0, 0, 0);
        check("R1 N=1 positive", result_o, 32'd0);

        // R8: strobed non-saturating op leaves flag 0
        apply(32'h0000_0003, 1'b0, 0, 4);
        valid_i = 1'b1;
        edge_then_sample;
        check("R8 strobed no sat", {31'b0, sticky_o}, 32'd0);

        // R7: strobed saturating op sets flag
        apply(32'h0000_1000, 1'b0, 0, 4);
        edge_then_sample;
        check("R7 set on sat", {31'b0, sticky_o}, 32'd1);

        // R8: non-saturating strobe keeps it set
        apply(32'h0000_0001, 1'b0, 0, 4);
        edge_then_sample;
        check("R8 hold set", {31'b0, sticky_o}, 32'd1);

        // R9: clear
        @(negedge clk);
        valid_i = 1'b0; clr_i = 1'b1;
        edge_then_sample;
        check("R9 clear", {31'b0, sticky_o}, 32'd0);

        // R9: clear with simultaneous strobed saturation -> set wins
        apply(32'hF000_0000, 1'b0, 0, 2);
        valid_i = 1'b1; clr_i = 1'b1;
        edge_then_sample;
        check("R9 set beats clear", {31'b0, sticky_o}, 32'd1);

        // R10: reset in mid-run clears the flag
        @(negedge clk);
        valid_i = 1'b0; clr_i = 1'b0; rst_n = 1'b0;
        edge_then_sample;
        check("R10 reset clears", {31'b0, sticky_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        edge_then_sample;

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule